// File: doc/BRIEF.md
# Bit-Serial Triple-Plus-One Unit

This block takes an unsigned operand X one bit per clock, least significant bit first, on a single data input. In the same cycle it drives the matching bit of Y = 3X + 1 on a single output, also least significant bit first. It forms 3X as X + 2X. The doubled operand is simply the input delayed by one bit, so the state is only that delayed bit and a one-bit running carry. The +1 is injected by starting the carry at one. The whole machine therefore has four states.

A stream is framed by a synchronous start pulse. A qualifying strobe marks the cycles that carry a bit. An n-bit operand produces a result that is n + 2 bits wide. The user feeds two zero bits after the operand to flush the top of the result. Cycles without the strobe leave the computation paused.

Top module: `serial_triple_inc`

## Requirements
- R1: An active-low asynchronous reset puts the machine in its initial state: delayed bit 0 and carry 1. An operand sent right after reset, without a start pulse, yields 3X + 1.
- R2: In a cycle with x_valid high, y equals x XOR delayed bit XOR carry, combinationally in the same cycle. When start is also high in that cycle, the initial state (delayed bit 0, carry 1) is used in place of the stored one.
- R3: On each clock edge with x_valid high, the delayed bit takes the value of x. The carry takes the majority of x, the delayed bit in use and the carry in use.
- R4: Feed an n-bit operand X (1 ≤ n ≤ 16) with bit 0 first, then two zero bits. The n + 2 output bits, read bit 0 first, equal 3X + 1.
- R5: A start pulse abandons any partial operand and begins a new one. If x_valid is high in the same cycle, that bit is bit 0 of the new operand. Otherwise the next valid bit is bit 0.
- R6: With x_valid low and start low, the state is held unchanged. y is 0 in every cycle where x_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Synchronous restart of the operand stream |
| x_valid | input | 1 | High in cycles that carry an operand bit |
| x | input | 1 | Operand bit, least significant first |
| y | output | 1 | Result bit of 3X + 1, least significant first |

## Verification
The bench builds the block with its default parameter, so the +1 comes from an initial carry of one. This makes every computed result depend on the initial carry. A table of operands covers widths from 1 to 16 bits, including all-ones values that keep the carry at one through the whole stream. Random operands follow. Directed sequences pause the stream in the middle of a carry chain, restart it over a partial operand, and drive start both with and without a bit in the same cycle.

// File: rtl/serial_triple_inc.sv
module serial_triple_inc #(
  parameter bit ADD_ONE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic x_valid,
  input  logic x,
  output logic y
);

  logic prev_q, cy_q;
  logic prev_use, cy_use, cy_nxt;

  assign prev_use = start ? 1'b0 : prev_q;
  assign cy_use   = start ? ADD_ONE : cy_q;
  assign cy_nxt   = (x & prev_use) | (x & cy_use) | (prev_use & cy_use);
  assign y        = x_valid & (x ^ prev_use ^ cy_use);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cy_q   <= ADD_ONE;
    end else if (x_valid) begin
      prev_q <= x;
      cy_q   <= cy_nxt;
    end else if (start) begin
      prev_q <= 1'b0;
      cy_q   <= ADD_ONE;
    end
  end

endmodule

module serial_triple_inc_chk #(
  parameter bit ADD_ONE = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic x_valid,
  input logic x,
  input logic y,
  input logic prev_q,
  input logic cy_q
);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!x_valid && !start) |=> ($stable(prev_q) && $stable(cy_q)));

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !x_valid |-> !y);

  // R5
  start_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !x_valid) |=> (!prev_q && (cy_q == ADD_ONE)));

  // R3
  prev_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    x_valid |=> (prev_q == $past(x)));

  // R3
  carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && !start && x && prev_q) |=> cy_q);

  // R2
  out_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && !start && !x && !prev_q && !cy_q) |-> !y);

endmodule

bind serial_triple_inc serial_triple_inc_chk #(.ADD_ONE(ADD_ONE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .x_valid(x_valid),
  .x(x), .y(y), .prev_q(prev_q), .cy_q(cy_q)
);

// File: tb/serial_triple_inc_bench.sv
`timescale 1ns/1ps
module serial_triple_inc_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic x_valid = 1'b0;
  logic x = 1'b0;
  logic y;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_triple_inc u_serial_triple_inc (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_valid(x_valid), .x(x), .y(y)
  );

  // width in [20:16], operand in [15:0]
  localparam logic [20:0] VECS [8] = '{
    {5'd1,  16'h0000}, {5'd1,  16'h0001}, {5'd4,  16'h000D},
    {5'd8,  16'h00FF}, {5'd16, 16'hFFFF}, {5'd16, 16'hA5A5},
    {5'd8,  16'h0080}, {5'd12, 16'h0AAA}
  };

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic bit_step(input logic s, input logic v, input logic b, output logic yo);
    @(negedge clk);
    start = s; x_valid = v; x = b;
    #1 yo = y;
  endtask

  task automatic run_num(input int n, input logic [15:0] val, input logic use_start, input string tag);
    logic [17:0] got;
    int exp;
    logic yo;
    got = '0;
    exp = 3 * int'(val) + 1;
    for (int i = 0; i < n + 2; i++) begin
      bit_step(use_start && (i == 0), 1'b1, (i < n) ? val[i] : 1'b0, yo);
      got[i] = yo;
    end
    check(int'(got) == exp, tag, int'(got), exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic yo;
    repeat (3) @(negedge clk);
    #1 check(y == 1'b0, "R6 reset idle", int'(y), 0);
    rst_n = 1'b1;

    // R1: no start after reset
    run_num(4, 16'd13, 1'b0, "R1");

    // R4: table walk
    for (int k = 0; k < 8; k++)
      run_num(int'(VECS[k][20:16]), VECS[k][15:0], 1'b1, "R4 table");

    // R4: random operands
    for (int k = 0; k < 20; k++) begin
      logic [15:0] v;
      v = 16'($urandom);
      run_num(16, v, 1'b1, "R4 random");
    end

    // R2 / R3: hand-traced sequence
    bit_step(1'b1, 1'b1, 1'b1, yo); check(yo == 1'b0, "R2 start bit", int'(yo), 0);
    bit_step(1'b0, 1'b1, 1'b1, yo); check(yo == 1'b1, "R3 p1c1 x1", int'(yo), 1);
    bit_step(1'b0, 1'b1, 1'b0, yo); check(yo == 1'b0, "R3 p1c1 x0", int'(yo), 0);
    bit_step(1'b0, 1'b1, 1'b0, yo); check(yo == 1'b1, "R3 p0c1 x0", int'(yo), 1);

    // R6: pause in the middle of a carry chain
    bit_step(1'b1, 1'b0, 1'b0, yo); check(yo == 1'b0, "R6 start idle", int'(yo), 0);
    bit_step(1'b0, 1'b1, 1'b1, yo); check(yo == 1'b0, "R6 first bit", int'(yo), 0);
    for (int k = 0; k < 3; k++) begin
      bit_step(1'b0, 1'b0, 1'b1, yo);
      check(yo == 1'b0, "R6 idle output", int'(yo), 0);
    end
    bit_step(1'b0, 1'b1, 1'b0, yo); check(yo == 1'b0, "R6 held state", int'(yo), 0);
    bit_step(1'b0, 1'b1, 1'b0, yo); check(yo == 1'b1, "R6 after hold", int'(yo), 1);

    // R5: restart over a partial operand
    for (int k = 0; k < 3; k++) bit_step(1'b0, 1'b1, 1'b1, yo);
    run_num(8, 16'h003C, 1'b1, "R5 start with bit");
    for (int k = 0; k < 2; k++) bit_step(1'b0, 1'b1, 1'b1, yo);
    bit_step(1'b1, 1'b0, 1'b0, yo);
    run_num(6, 16'd45, 1'b0, "R5 start alone");

    @(negedge clk);
    start = 1'b0; x_valid = 1'b0; x = 1'b0;
    finish_run();
  end

endmodule